// File: doc/BRIEF.md
# Serially Loaded Dual-Port Challenge Byte Store

This block keeps a short challenge value, ten bytes long, in a bank of flip-flops. The challenge is loaded one byte per write strobe, and the bytes move through the cells like a shift register. There is no write address. Loading happens once, while the surrounding engine is being set up, and is finished before any result is read.

After loading, two read ports can each fetch any stored byte in the same cycle. A multiply-accumulate datapath uses this to take two different challenge bytes as its operands at once. Each read port is only a byte-wide multiplexer over the same flip-flops, so the second port adds no storage. Reads are combinational. A 4-bit read address covers the ten cells, and the six codes above the top cell return zero.

Top module: `chal_dual_read_store`

## Requirements
- R1: A synchronous active-high reset (`rst` high at a rising clock edge) clears all ten cells to 0x00, so every read address returns 0x00 after reset.
- R2: At each rising edge with `wr_en` high, `wr_byte` goes into cell 9, and the byte held in cell k (k from 1 to 9) moves to cell k-1.
- R3: After exactly ten write strobes from reset, the n-th byte written (n from 1 to 10) is read at address n-1, so the first byte written is at address 0.
- R4: A write strobe when the store already holds ten written bytes drops the byte at address 0. Every other byte moves down one address, and the new byte is placed at address 9.
- R5: At a rising edge with `wr_en` low, every cell keeps its value whatever `wr_byte` carries.
- R6: `rd_data_a` shows the cell selected by the 4-bit `rd_addr_a` (codes 0 to 9) in the same cycle, with no clock edge in between.
- R7: `rd_data_b` is selected by `rd_addr_b` independently of port A. Both ports may select different cells, or the same cell, in the same cycle.
- R8: A read address from 10 to 15 on either port returns 0x00.
- R9: In a cycle where `wr_en` is high, both read ports still return the contents from before that cycle's rising edge. The new contents appear only after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe: shift `wr_byte` in at this edge |
| wr_byte | input | 8 | Byte entering cell 9 |
| rd_addr_a | input | 4 | Port A cell select |
| rd_data_a | output | 8 | Port A byte, combinational |
| rd_addr_b | input | 4 | Port B cell select |
| rd_data_b | output | 8 | Port B byte, combinational |

## Verification
The hardest state to reach from the ports is the overflow case. Ten writes must first fill the store with known bytes, and one more strobe must then drop the oldest byte while both ports look at the two ends of the cell row. The bench gets there by loading a distinct ten-byte pattern and walking a table of address pairs against it, including out-of-range codes. It then sends one extra byte with the strobe held and the ports pointed at addresses 0 and 9. It checks the pre-edge values in that same cycle and the shifted values after the edge. This covers overflow and the read-during-write ordering in one step.

// File: rtl/chal_store_pkg.sv
package chal_store_pkg;

    localparam int unsigned CHAL_BYTES  = 10;
    localparam int unsigned CHAL_WIDTH  = 8;
    localparam int unsigned CHAL_ADDR_W = 4;
    localparam int unsigned CHAL_PORTS  = 2;

    typedef logic [CHAL_WIDTH-1:0]  chal_byte_t;
    typedef logic [CHAL_ADDR_W-1:0] chal_addr_t;

    typedef struct packed {
        chal_addr_t addr;
        chal_byte_t data;
    } chal_rd_port_t;

    // True when an address code selects a real cell.
    function automatic logic addr_in_range(input int unsigned code, input int unsigned depth);
        return code < depth;
    endfunction

endpackage

// File: rtl/chal_shift_cells.sv
module chal_shift_cells
    import chal_store_pkg::*;
#(
    parameter int unsigned DEPTH = CHAL_BYTES,
    parameter int unsigned WIDTH = CHAL_WIDTH
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        shift_en,
    input  logic [WIDTH-1:0]            shift_in,
    output logic [DEPTH-1:0][WIDTH-1:0] cells
);

    localparam int unsigned TOP = DEPTH - 1;

    logic [DEPTH-1:0][WIDTH-1:0] cells_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cells_q <= '0;
        end else if (shift_en) begin
            for (int unsigned k = 0; k < TOP; k++) begin
                cells_q[k] <= cells_q[k+1];
            end
            cells_q[TOP] <= shift_in;
        end
    end

    assign cells = cells_q;

    // Reset empties every cell.
    assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (cells_q == '0));

    // New byte lands in the top cell.
    assert_top_load_R2: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (cells_q[TOP] == $past(shift_in)));

    // Each lower cell takes its upper neighbour (oldest byte drops out, R4).
    genvar g;
    generate
        for (g = 0; g < TOP; g++) begin : g_shift_chk
            assert_move_down_R4: assert property (@(posedge clk) disable iff (rst)
                shift_en |=> (cells_q[g] == $past(cells_q[g+1])));
        end
    endgenerate

    // No strobe, no change.
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(cells_q));

endmodule

// File: rtl/chal_read_mux.sv
module chal_read_mux
    import chal_store_pkg::*;
#(
    parameter int unsigned DEPTH  = CHAL_BYTES,
    parameter int unsigned WIDTH  = CHAL_WIDTH,
    parameter int unsigned ADDR_W = CHAL_ADDR_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [DEPTH-1:0][WIDTH-1:0] cells,
    input  logic [ADDR_W-1:0]           sel,
    output logic [WIDTH-1:0]            dout
);

    always_comb begin
        dout = '0;
        for (int unsigned k = 0; k < DEPTH; k++) begin
            if (sel == ADDR_W'(k)) begin
                dout = cells[k];
            end
        end
    end

    // Unused address codes read as zero.
    assert_unused_code_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !addr_in_range(int'(sel), DEPTH) |-> (dout == '0));

endmodule

// File: rtl/chal_dual_read_store.sv
module chal_dual_read_store
    import chal_store_pkg::*;
#(
    parameter int unsigned DEPTH  = CHAL_BYTES,
    parameter int unsigned WIDTH  = CHAL_WIDTH,
    parameter int unsigned ADDR_W = CHAL_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WIDTH-1:0]  wr_byte,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [WIDTH-1:0]  rd_data_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [WIDTH-1:0]  rd_data_b
);

    localparam int unsigned NPORTS = CHAL_PORTS;

    logic [DEPTH-1:0][WIDTH-1:0] cells;
    logic [NPORTS-1:0][ADDR_W-1:0] sel_vec;
    logic [NPORTS-1:0][WIDTH-1:0]  dout_vec;

    chal_shift_cells #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH)
    ) u_cells (
        .clk      (clk),
        .rst      (rst),
        .shift_en (wr_en),
        .shift_in (wr_byte),
        .cells    (cells)
    );

    assign sel_vec[0] = rd_addr_a;
    assign sel_vec[1] = rd_addr_b;

    genvar p;
    generate
        for (p = 0; p < NPORTS; p++) begin : g_port
            chal_read_mux #(
                .DEPTH  (DEPTH),
                .WIDTH  (WIDTH),
                .ADDR_W (ADDR_W)
            ) u_mux (
                .clk   (clk),
                .rst   (rst),
                .cells (cells),
                .sel   (sel_vec[p]),
                .dout  (dout_vec[p])
            );
        end
    endgenerate

    assign rd_data_a = dout_vec[0];
    assign rd_data_b = dout_vec[1];

    // Two ports on one cell agree.
    assert_ports_agree_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b));

    // Port A reading the top cell during a strobe sees the new byte only after the edge.
    assert_read_after_write_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_addr_a == ADDR_W'(DEPTH-1)) ##1 (rd_addr_a == ADDR_W'(DEPTH-1))
        |-> (rd_data_a == $past(wr_byte)));

endmodule

// File: tb/test_chal_dual_read_store.sv
module test_chal_dual_read_store;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic [3:0] rd_addr_a = 4'd0;
    logic [7:0] rd_data_a;
    logic [3:0] rd_addr_b = 4'd0;
    logic [7:0] rd_data_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    chal_dual_read_store i_chal_dual_read_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_byte   (wr_byte),
        .rd_addr_a (rd_addr_a),
        .rd_data_a (rd_data_a),
        .rd_addr_b (rd_addr_b),
        .rd_data_b (rd_data_b)
    );

    // Loaded pattern: n-th byte written (n = 1..10).
    function automatic logic [7:0] pat(input int n);
        return (n == 10) ? 8'hA5 : 8'(n * 17);
    endfunction

    // {addr_a, addr_b, expected_a, expected_b} against the loaded pattern.
    localparam int NVEC = 8;
    localparam logic [23:0] VEC [NVEC] = '{
        {4'd0,  4'd9,  8'h11, 8'hA5},
        {4'd3,  4'd3,  8'h44, 8'h44},
        {4'd5,  4'd2,  8'h66, 8'h33},
        {4'd10, 4'd15, 8'h00, 8'h00},
        {4'd12, 4'd1,  8'h00, 8'h22},
        {4'd9,  4'd0,  8'hA5, 8'h11},
        {4'd7,  4'd8,  8'h88, 8'h99},
        {4'd4,  4'd11, 8'h55, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic write_one(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_byte = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_pair(input logic [3:0] a, input logic [3:0] b);
        rd_addr_a = a;
        rd_addr_b = b;
        #1;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: every cell reads zero after reset
        for (int a = 0; a < 10; a++) begin
            read_pair(4'(a), 4'(9 - a));
            check("R1 port A", rd_data_a, 8'h00);
            check("R1 port B", rd_data_b, 8'h00);
        end

        // R2: partial load
        write_one(8'h5A);
        read_pair(4'd9, 4'd8);
        check("R2 first byte in cell 9", rd_data_a, 8'h5A);
        check("R2 cell 8 still zero", rd_data_b, 8'h00);
        write_one(8'h6B);
        read_pair(4'd9, 4'd8);
        check("R2 new byte in cell 9", rd_data_a, 8'h6B);
        check("R2 older byte moved to cell 8", rd_data_b, 8'h5A);

        // Reset again, then full load (R3)
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        read_pair(4'd9, 4'd8);
        check("R1 reset after writes", rd_data_a, 8'h00);
        for (int n = 1; n <= 10; n++) write_one(pat(n));
        for (int n = 1; n <= 10; n++) begin
            read_pair(4'(n - 1), 4'(n - 1));
            check("R3 n-th byte at n-1", rd_data_a, pat(n));
        end

        // R6 R7 R8: table of address pairs
        for (int v = 0; v < NVEC; v++) begin
            read_pair(VEC[v][23:20], VEC[v][19:16]);
            check("R6 port A table", rd_data_a, VEC[v][15:8]);
            check("R7 R8 port B table", rd_data_b, VEC[v][7:0]);
        end

        // R5: no strobe, changing data has no effect
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            wr_byte = 8'hF0 + 8'(k);
        end
        @(negedge clk);
        read_pair(4'd0, 4'd9);
        check("R5 cell 0 held", rd_data_a, 8'h11);
        check("R5 cell 9 held", rd_data_b, 8'hA5);

        // R9 + R4: overflow write with ports on both ends
        @(negedge clk);
        read_pair(4'd0, 4'd9);
        wr_en = 1'b1;
        wr_byte = 8'hEE;
        #1;
        check("R9 port A pre-edge", rd_data_a, 8'h11);
        check("R9 port B pre-edge", rd_data_b, 8'hA5);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R4 oldest dropped, cell 0", rd_data_a, 8'h22);
        check("R4 new byte in cell 9", rd_data_b, 8'hEE);
        read_pair(4'd8, 4'd13);
        check("R4 previous top moved to 8", rd_data_a, 8'hA5);
        check("R8 code 13 zero", rd_data_b, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule